// File: doc/BRIEF.md
# Pre/Post-Trigger Capture Sequencer

This block records a window of samples around a trigger. It keeps a programmable number of samples taken before the trigger and a programmable number taken after it. An internal rate generator paces the sampling. Every sample tick writes the current input word into a local synchronous FIFO. After a start command, the sequencer first lets the FIFO fill to the pre-trigger depth. From then on, each new sample also discards the oldest stored sample in the same cycle, so the FIFO holds only the most recent pre-trigger samples.

The first trigger after start ends the discarding and raises a one-cycle interrupt pulse. It also switches the FIFO readout over to the host, which may begin draining while the post-trigger samples are still arriving. A post-trigger counter then admits a fixed number of further writes and halts sampling. Capture is then complete. Flags report a done capture, a trigger that arrived before the pre-fill finished, and a write lost to a full FIFO.

Top module: `prepost_capture`

## Requirements
- R1: After reset, and again on the cycle after a start pulse, the FIFO is empty. After either event, the flags done, short_pre, overflow, irq and host_mode read 0. A start also latches pre_n, post_m and period and makes busy read 1.
- R2: While busy, fifo_wr is high for one cycle in every period+1 cycles. The first high cycle is the (period+1)-th cycle after the start edge. Each high cycle stores sample_in into the FIFO.
- R3: During pre-fill, no sample is discarded. Once pre_n samples have been written, the sequencer enters the hold phase with fifo_level equal to pre_n.
- R4: In the hold phase, fifo_discard is high in exactly the cycles in which fifo_wr is high. The write and the discard are applied together, so fifo_level stays unchanged.
- R5: A trigger_in that is high in the pre-fill or hold phase is accepted. From the next cycle on, there are no more discards and host_mode reads 1. irq is high for exactly that next cycle.
- R6: After an accepted trigger, exactly post_m more writes occur. On the edge of the last of them, busy falls and done rises. done then stays high until the next start.
- R7: If the trigger is accepted before pre_n samples have been written, short_pre reads 1 until the next start. A sample written in the trigger cycle counts toward pre_n.
- R8: A trigger while idle, after an accepted trigger, or after done has no effect: irq stays low and the capture sequence is unchanged.
- R9: A write that finds the FIFO full with no pop in the same cycle is dropped. It sets overflow, which stays set until the next start.
- R10: fifo_dout shows the oldest stored sample. host_rd removes one sample only while host_mode is 1 and the FIFO is not empty. Otherwise host_rd has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse: flush, latch configuration, begin sampling |
| trigger_in | input | 1 | Trigger event |
| pre_n | input | CNT_W | Pre-trigger sample count (at least 1) |
| post_m | input | CNT_W | Post-trigger sample count (at least 1) |
| period | input | DIV_W | Sample period minus one, in clocks |
| sample_in | input | DATA_W | Sample data word |
| host_rd | input | 1 | Host read strobe |
| fifo_wr | output | 1 | Sample write strobe |
| fifo_discard | output | 1 | Discard strobe for the oldest sample |
| fifo_dout | output | DATA_W | Oldest stored sample |
| fifo_level | output | LVL_W | FIFO occupancy |
| irq | output | 1 | One-cycle pulse on an accepted trigger |
| host_mode | output | 1 | FIFO readout handed to host |
| busy | output | 1 | Sampling active |
| done | output | 1 | Post-trigger count complete |
| short_pre | output | 1 | Trigger arrived before pre-fill completed |
| overflow | output | 1 | A write was lost to a full FIFO |

## Verification
A wrong phase in the sequencer shows up at the ports on the next sample tick at the latest. A stray or missing fifo_discard appears during hold, and fifo_level then drifts away from pre_n on the following edge. A miscounted post-trigger counter moves the edge where busy falls and done rises by whole sample periods. A pointer or occupancy fault in the FIFO shows within one cycle, as a wrong fifo_dout word or fifo_level value. The bench's model compares every output on every cycle, so such faults are reported on the first cycle they become visible.

// File: rtl/capture_seq_pkg.sv
package capture_seq_pkg;

    parameter int CNT_W = 8;
    parameter int DIV_W = 8;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_FILL,
        PH_HOLD,
        PH_POST,
        PH_DONE
    } phase_t;

    typedef struct packed {
        logic [CNT_W-1:0] pre_n;
        logic [CNT_W-1:0] post_m;
    } window_cfg_t;

    function automatic logic phase_triggerable(phase_t ph);
        return (ph == PH_FILL) || (ph == PH_HOLD);
    endfunction

    function automatic logic phase_running(phase_t ph);
        return (ph == PH_FILL) || (ph == PH_HOLD) || (ph == PH_POST);
    endfunction

endpackage

// File: rtl/sample_rate_gen.sv
module sample_rate_gen
    import capture_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= (cnt_q == div) ? '0 : cnt_q + DIV_W'(1);
        end
    end

    assign tick = run && (cnt_q == div);

endmodule

// File: rtl/sample_fifo.sv
module sample_fifo #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 16,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              push,
    input  logic              pop,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic [LVL_W-1:0]  level,
    output logic              full,
    output logic              empty,
    output logic              ovf
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wptr_q, rptr_q;
    logic [LVL_W-1:0]  cnt_q;
    logic              ovf_q;
    logic              do_push, do_pop;

    assign full    = (cnt_q == LVL_W'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign do_pop  = pop && !empty && !flush;
    assign do_push = push && (!full || do_pop) && !flush;

    function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
            ovf_q  <= 1'b0;
        end else begin
            if (do_push) wptr_q <= bump(wptr_q);
            if (do_pop)  rptr_q <= bump(rptr_q);
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + LVL_W'(1);
                2'b01:   cnt_q <= cnt_q - LVL_W'(1);
                default: cnt_q <= cnt_q;
            endcase
            if (push && full && !do_pop) ovf_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr_q] <= din;
    end

    assign dout  = mem[rptr_q];
    assign level = cnt_q;
    assign ovf   = ovf_q;

    a_r4_level_steady: assert property (@(posedge clk) disable iff (rst)
        (push && pop && !empty && !flush) |=> $stable(level));
    a_r9_overflow_sticky: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop && !flush) |=> ovf);
    a_r9_level_bound: assert property (@(posedge clk) disable iff (rst)
        level <= LVL_W'(DEPTH));

endmodule

// File: rtl/window_ctrl.sv
module window_ctrl
    import capture_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             trig,
    input  logic             tick,
    input  logic [CNT_W-1:0] pre_n,
    input  logic [CNT_W-1:0] post_m,
    output logic             run,
    output logic             discard,
    output logic             irq,
    output logic             host_mode,
    output logic             done,
    output logic             short_pre
);
    phase_t           ph_q;
    window_cfg_t      cfg_q;
    logic [CNT_W-1:0] pre_cnt_q, post_cnt_q;
    logic [CNT_W-1:0] pre_inc, post_inc;
    logic             irq_q, host_q, done_q, short_q;

    assign pre_inc  = pre_cnt_q + CNT_W'(1);
    assign post_inc = post_cnt_q + CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q       <= PH_IDLE;
            cfg_q      <= '0;
            pre_cnt_q  <= '0;
            post_cnt_q <= '0;
            irq_q      <= 1'b0;
            host_q     <= 1'b0;
            done_q     <= 1'b0;
            short_q    <= 1'b0;
        end else if (start) begin
            ph_q       <= PH_FILL;
            cfg_q      <= '{pre_n: pre_n, post_m: post_m};
            pre_cnt_q  <= '0;
            post_cnt_q <= '0;
            irq_q      <= 1'b0;
            host_q     <= 1'b0;
            done_q     <= 1'b0;
            short_q    <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            case (ph_q)
                PH_FILL: if (tick) begin
                    pre_cnt_q <= pre_inc;
                    if (pre_inc == cfg_q.pre_n) ph_q <= PH_HOLD;
                end
                PH_POST: if (tick) begin
                    post_cnt_q <= post_inc;
                    if (post_inc == cfg_q.post_m) begin
                        ph_q   <= PH_DONE;
                        done_q <= 1'b1;
                    end
                end
                default: ;
            endcase
            if (trig && phase_triggerable(ph_q)) begin
                ph_q       <= PH_POST;
                post_cnt_q <= '0;
                irq_q      <= 1'b1;
                host_q     <= 1'b1;
                short_q    <= (ph_q == PH_FILL) && !(tick && pre_inc == cfg_q.pre_n);
            end
        end
    end

    assign run       = phase_running(ph_q);
    assign discard   = tick && (ph_q == PH_HOLD);
    assign irq       = irq_q;
    assign host_mode = host_q;
    assign done      = done_q;
    assign short_pre = short_q;

    a_r6_done_sticky: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done);
    a_r8_single_irq: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);
    a_r5_irq_hands_over: assert property (@(posedge clk) disable iff (rst)
        irq |-> (host_mode && !discard));

endmodule

// File: rtl/prepost_capture.sv
module prepost_capture
    import capture_seq_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 16,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              trigger_in,
    input  logic [CNT_W-1:0]  pre_n,
    input  logic [CNT_W-1:0]  post_m,
    input  logic [DIV_W-1:0]  period,
    input  logic [DATA_W-1:0] sample_in,
    input  logic              host_rd,
    output logic              fifo_wr,
    output logic              fifo_discard,
    output logic [DATA_W-1:0] fifo_dout,
    output logic [LVL_W-1:0]  fifo_level,
    output logic              irq,
    output logic              host_mode,
    output logic              busy,
    output logic              done,
    output logic              short_pre,
    output logic              overflow
);
    logic             tick, run, discard, host_q;
    logic             f_full, f_empty;
    logic [DIV_W-1:0] period_q;

    always_ff @(posedge clk) begin
        if (rst)        period_q <= '0;
        else if (start) period_q <= period;
    end

    sample_rate_gen u_rate (
        .clk     (clk),
        .rst     (rst),
        .restart (start),
        .run     (run),
        .div     (period_q),
        .tick    (tick)
    );

    window_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .trig      (trigger_in),
        .tick      (tick),
        .pre_n     (pre_n),
        .post_m    (post_m),
        .run       (run),
        .discard   (discard),
        .irq       (irq),
        .host_mode (host_q),
        .done      (done),
        .short_pre (short_pre)
    );

    sample_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .flush (start),
        .push  (tick),
        .pop   (discard || (host_rd && host_q)),
        .din   (sample_in),
        .dout  (fifo_dout),
        .level (fifo_level),
        .full  (f_full),
        .empty (f_empty),
        .ovf   (overflow)
    );

    assign fifo_wr      = tick;
    assign fifo_discard = discard;
    assign host_mode    = host_q;
    assign busy         = run;

    a_r4_discard_paired: assert property (@(posedge clk) disable iff (rst)
        fifo_discard |-> fifo_wr);
    a_r6_quiet_after_done: assert property (@(posedge clk) disable iff (rst)
        done |-> (!fifo_wr && !busy));
    a_r10_no_pop_when_empty: assert property (@(posedge clk) disable iff (rst)
        (f_empty && !fifo_wr && !start) |=> (fifo_level == '0));
    a_r1_start_flushes: assert property (@(posedge clk) disable iff (rst)
        start |=> (fifo_level == '0 && busy && !done && !overflow));

endmodule

// File: tb/prepost_capture_tb.sv
module prepost_capture_tb_top;
    import capture_seq_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int DATA_W = 16;
    localparam int DEPTH  = 16;
    localparam int LVL_W  = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0, trigger_in = 1'b0, host_rd = 1'b0;
    logic [CNT_W-1:0] pre_n = '0, post_m = '0;
    logic [DIV_W-1:0] period = '0;
    logic [DATA_W-1:0] sample_in = '0;
    logic fifo_wr, fifo_discard, irq, host_mode, busy, done, short_pre, overflow;
    logic [DATA_W-1:0] fifo_dout;
    logic [LVL_W-1:0] fifo_level;

    always #(CLK_PERIOD/2) clk = ~clk;

    prepost_capture #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dut_i (.*);

    int checks = 0, fails = 0, cycles = 0;

    // behavioural reference: phases 0 idle, 1 fill, 2 hold, 3 post, 4 done
    int m_ph = 0, m_pc = 0, m_div = 0, m_n = 0, m_m = 0, m_pre = 0, m_post = 0;
    bit m_irq = 0, m_host = 0, m_done = 0, m_short = 0, m_ovf = 0;
    logic [DATA_W-1:0] q[$];

    function automatic bit m_run();
        return m_ph >= 1 && m_ph <= 3;
    endfunction
    function automatic bit m_tick();
        return m_run() && (m_pc == m_div);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_ph = 0; m_pc = 0; m_div = 0; m_pre = 0; m_post = 0;
            m_irq = 0; m_host = 0; m_done = 0; m_short = 0; m_ovf = 0;
            q.delete();
        end else begin
            bit t, popped;
            int ph;
            t = m_tick();
            ph = m_ph;
            if (start) begin
                q.delete();
                m_n = int'(pre_n); m_m = int'(post_m); m_div = int'(period);
                m_ph = 1; m_pc = 0; m_pre = 0; m_post = 0;
                m_irq = 0; m_host = 0; m_done = 0; m_short = 0; m_ovf = 0;
            end else begin
                popped = 0;
                if (((t && ph == 2) || (host_rd && m_host)) && q.size() > 0) begin
                    void'(q.pop_front());
                    popped = 1;
                end
                if (t) begin
                    if (q.size() < DEPTH) q.push_back(sample_in);
                    else m_ovf = 1;
                end
                if (m_run()) m_pc = (m_pc == m_div) ? 0 : m_pc + 1;
                m_irq = 0;
                if (ph == 1 && t) begin
                    m_pre++;
                    if (m_pre == m_n) m_ph = 2;
                end
                if (ph == 3 && t) begin
                    m_post++;
                    if (m_post == m_m) begin m_ph = 4; m_done = 1; end
                end
                if (trigger_in && (ph == 1 || ph == 2)) begin
                    m_short = (ph == 1) && (m_pre < m_n);
                    m_ph = 3; m_post = 0; m_irq = 1; m_host = 1;
                end
            end
        end
    end

    task automatic chk(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", req, what, act, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (!rst) begin
            chk("R2", "fifo_wr", fifo_wr, m_tick());
            chk("R4", "fifo_discard", fifo_discard, m_tick() && m_ph == 2);
            chk("R3", "fifo_level", fifo_level, q.size());
            chk("R5 R8", "irq", irq, m_irq);
            chk("R5", "host_mode", host_mode, m_host);
            chk("R6", "busy", busy, m_run());
            chk("R6", "done", done, m_done);
            chk("R7", "short_pre", short_pre, m_short);
            chk("R9", "overflow", overflow, m_ovf);
            if (q.size() > 0) chk("R10", "fifo_dout", fifo_dout, q[0]);
        end
        if (cycles > 20000) begin
            fails++; checks++;
            $display("FAIL watchdog: actual %0d expected below 20000 cycles", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    always @(negedge clk) sample_in <= sample_in + 16'h0103;

    task automatic go(int n, int m, int p);
        @(negedge clk);
        pre_n = CNT_W'(n); post_m = CNT_W'(m); period = DIV_W'(p);
        start = 1;
        @(negedge clk);
        start = 0;
    endtask

    task automatic pulse_trig();
        @(negedge clk); trigger_in = 1;
        @(negedge clk); trigger_in = 0;
    endtask

    task automatic pulse_rd(int k);
        for (int i = 0; i < k; i++) begin
            @(negedge clk); host_rd = 1;
            @(negedge clk); host_rd = 0;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1", "level after reset", fifo_level, 0);
        chk("R1", "flags after reset", {done, short_pre, overflow, irq, host_mode, busy}, 0);
        // R8 idle trigger and R10 idle read ignored
        pulse_trig();
        pulse_rd(2);
        chk("R8", "busy after idle trigger", busy, 0);
        // normal window with hold phase
        go(4, 5, 2);
        chk("R1", "busy after start", busy, 1);
        repeat (40) @(negedge clk);
        chk("R4", "hold level", fifo_level, 4);
        pulse_rd(2);
        chk("R10", "read ignored before trigger", fifo_level, 4);
        pulse_trig();
        repeat (3) @(negedge clk);
        pulse_trig();
        chk("R8", "second trigger irq", irq, 0);
        repeat (30) @(negedge clk);
        chk("R6", "done after post count", done, 1);
        chk("R6", "level N+M", fifo_level, 9);
        pulse_trig();
        pulse_rd(12);
        chk("R10", "drained", fifo_level, 0);
        // early trigger, period 0
        go(6, 3, 0);
        @(negedge clk);
        pulse_trig();
        repeat (10) @(negedge clk);
        chk("R7", "short flag", short_pre, 1);
        // overflow: N+M beyond depth
        go(10, 10, 1);
        repeat (30) @(negedge clk);
        pulse_trig();
        repeat (40) @(negedge clk);
        chk("R9", "overflow flag", overflow, 1);
        // restart in mid capture
        go(3, 4, 3);
        repeat (9) @(negedge clk);
        go(2, 2, 0);
        chk("R1", "restart clears", {done, overflow, short_pre}, 0);
        repeat (6) @(negedge clk);
        pulse_trig();
        repeat (10) @(negedge clk);
        pulse_rd(5);
        repeat (4) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule